// File: doc/BRIEF.md
# Floating-Point Compare Condition-Code Unit

This block compares two IEEE-754 operands, either both single precision or both double precision, and records the outcome in a status word that it owns. The outcome is a 2-bit relation code. It goes into one of four condition-code slots, chosen by a select input. An unordered outcome means at least one operand is a NaN. Its handling depends on an invalid-operation trap enable: with the enable set, the block raises a trap; with it clear, the block marks an accrued invalid flag.

A signaling flag asks for the stricter compare. When that flag is set and either operand is any NaN, quiet or signaling, and the trap is enabled, the trap is raised on an early path ahead of the ordinary relation logic. The non-signaling compare has no NaN check of its own. It traps only through the unordered rule. With these rules, both variants give the same result for every input.

A one-cycle strobe starts a compare. The updated status word, a trap pulse and a done pulse all appear on the clock edge that samples the strobe.

Top module: `fpcc_unit`

## Requirements
- R1: While reset is high, and after it is released, the status word is all zeros and done and trap are low.
- R2: A compare strobed in cycle n gives a one-cycle done pulse in cycle n+1. With no strobe there is no done, no trap, and the status word holds its value.
- R3: An ordered result writes the relation code into the selected slot: 00 for equal, 01 for A below B, 10 for A above B. Positive and negative zero compare equal.
- R4: Slot select 0, 1, 2 or 3 writes the status bits at CC_BASE plus 0, 22, 24 or 26, which is bits 11:10, 33:32, 35:34 or 37:36 by default. The other slots are not changed.
- R5: With the precision input at 0, only bits 31:0 of each operand are used, split as sign bit 31, 8-bit exponent and 23-bit fraction. With it at 1, all 64 bits are used, split as sign bit 63, 11-bit exponent and 52-bit fraction.
- R6: Values are ordered first by sign and then by magnitude, and infinities are included. Between two negative values, the larger magnitude is the lower value.
- R7: An unordered result with the trap enable clear writes 11 into the selected slot and sets the sticky accrued-invalid bit, status bit 9. No trap is raised.
- R8: An unordered result with the trap enable set leaves every slot unchanged. It sets the current-invalid bit, status bit 4, writes trap-type 001 into status bits 16:14, and pulses trap together with done.
- R9: Every compare first clears the trap-type field, so a non-trapping compare leaves bits 16:14 at 000.
- R10: With the signaling flag set and the trap enable set, a quiet NaN operand causes the trap described in R8. With the trap enable clear, the result follows R7.
- R11: A NaN has every exponent bit set and a nonzero fraction. An all-ones exponent with a zero fraction is an infinity and is ordered normally.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| valid_i | input | 1 | Compare strobe |
| dbl_i | input | 1 | 1 selects double precision, 0 selects single |
| slot_i | input | 2 | Condition-code slot select |
| signaling_i | input | 1 | Signaling compare variant |
| trap_en_i | input | 1 | Invalid-operation trap enable |
| op_a_i | input | 64 | Operand A (single uses bits 31:0) |
| op_b_i | input | 64 | Operand B (single uses bits 31:0) |
| status_o | output | 64 | Status word with the slots, trap type and invalid flags |
| trap_o | output | 1 | Trap request pulse |
| done_o | output | 1 | Result-valid pulse |

## Verification
The bench aims at the cases where a compare is easy to get wrong. One is signed zeros: a unit that compared raw bit patterns would report 10 for +0 against -0 instead of 00. Another is a pair of negative operands, where a unit that did not reverse the magnitude order would give the opposite code. Infinity against the largest finite value also matters, because a unit that took an all-ones exponent for a NaN would report unordered there. In single precision, garbage is placed in the upper operand bits; a unit that looked at those bits would no longer report equal.

On the trap side, the bench checks that a trapping compare leaves all four slots untouched. It also checks that the next compare clears the trap-type field, and that every slot lands at its own offset without disturbing its neighbours.

// File: rtl/fpcc_pkg.sv
package fpcc_pkg;

  localparam int SP_EXP = 8;
  localparam int SP_MAN = 23;
  localparam int DP_EXP = 11;
  localparam int DP_MAN = 52;
  localparam int KEY_W  = DP_EXP + DP_MAN;

  typedef enum logic [1:0] {
    REL_EQ = 2'b00,
    REL_LT = 2'b01,
    REL_GT = 2'b10,
    REL_UN = 2'b11
  } rel_e;

  typedef struct packed {
    logic             sign;
    logic             nan;
    logic             zero;
    logic [KEY_W-1:0] key;
  } opnd_t;

  // bit offset of each condition-code slot relative to the base slot
  function automatic int unsigned slot_offset(input logic [1:0] slot);
    case (slot)
      2'd0:    return 0;
      2'd1:    return 22;
      2'd2:    return 24;
      default: return 26;
    endcase
  endfunction

endpackage

// File: rtl/fpcc_unpack.sv
module fpcc_unpack
  import fpcc_pkg::*;
#(
  parameter int EXP_S = SP_EXP,
  parameter int MAN_S = SP_MAN,
  parameter int EXP_D = DP_EXP,
  parameter int MAN_D = DP_MAN
) (
  input  logic [EXP_D+MAN_D:0] raw_i,
  input  logic                 dbl_i,
  output opnd_t                opnd_o
);
  localparam int SW = 1 + EXP_S + MAN_S;

  logic [EXP_S-1:0] s_exp;
  logic [MAN_S-1:0] s_man;
  logic [EXP_D-1:0] d_exp;
  logic [MAN_D-1:0] d_man;

  assign s_exp = raw_i[SW-2 -: EXP_S];
  assign s_man = raw_i[MAN_S-1:0];
  assign d_exp = raw_i[EXP_D+MAN_D-1 -: EXP_D];
  assign d_man = raw_i[MAN_D-1:0];

  always_comb begin
    if (dbl_i) begin
      opnd_o.sign = raw_i[EXP_D+MAN_D];
      opnd_o.nan  = (&d_exp) && (|d_man);
      opnd_o.key  = KEY_W'({d_exp, d_man});
    end else begin
      opnd_o.sign = raw_i[SW-1];
      opnd_o.nan  = (&s_exp) && (|s_man);
      opnd_o.key  = KEY_W'({s_exp, s_man});
    end
    opnd_o.zero = (opnd_o.key == '0);
  end
endmodule

// File: rtl/fpcc_order.sv
module fpcc_order
  import fpcc_pkg::*;
(
  input  opnd_t a_i,
  input  opnd_t b_i,
  output rel_e  rel_o,
  output logic  any_nan_o
);
  logic mag_lt;
  logic mag_eq;

  assign any_nan_o = a_i.nan | b_i.nan;
  assign mag_lt    = (a_i.key < b_i.key);
  assign mag_eq    = (a_i.key == b_i.key);

  always_comb begin
    if (any_nan_o)                rel_o = REL_UN;
    else if (a_i.zero && b_i.zero) rel_o = REL_EQ;
    else if (a_i.sign != b_i.sign) rel_o = a_i.sign ? REL_LT : REL_GT;
    else if (mag_eq)               rel_o = REL_EQ;
    else if (mag_lt ^ a_i.sign)    rel_o = REL_LT;
    else                           rel_o = REL_GT;
  end
endmodule

// File: rtl/fpcc_status.sv
module fpcc_status
  import fpcc_pkg::*;
#(
  parameter int STAT_W    = 64,
  parameter int CC_BASE   = 10,
  parameter int FTT_LSB   = 14,
  parameter int FTT_W     = 3,
  parameter int FTT_IEEE  = 1,
  parameter int NVC_BIT   = 4,
  parameter int NVA_BIT   = 9
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              valid_i,
  input  rel_e              rel_i,
  input  logic              any_nan_i,
  input  logic [1:0]        slot_i,
  input  logic              signaling_i,
  input  logic              trap_en_i,
  output logic [STAT_W-1:0] status_o,
  output logic              trap_o,
  output logic              done_o
);
  logic [STAT_W-1:0] stat_q, stat_d;
  logic              raise;
  logic              early;
  int unsigned       pos;

  assign pos   = CC_BASE + slot_offset(slot_i);
  assign early = signaling_i && any_nan_i && trap_en_i;

  always_comb begin
    stat_d = stat_q;
    stat_d[FTT_LSB +: FTT_W] = '0;
    raise = early || ((rel_i == REL_UN) && trap_en_i);
    if (raise) begin
      stat_d[NVC_BIT] = 1'b1;
      stat_d[FTT_LSB +: FTT_W] = FTT_W'(FTT_IEEE);
    end else begin
      stat_d[pos +: 2] = rel_i;
      if (rel_i == REL_UN) stat_d[NVA_BIT] = 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      stat_q <= '0;
      trap_o <= 1'b0;
      done_o <= 1'b0;
    end else begin
      done_o <= valid_i;
      trap_o <= valid_i && raise;
      if (valid_i) stat_q <= stat_d;
    end
  end

  assign status_o = stat_q;
endmodule

// File: rtl/fpcc_unit.sv
module fpcc_unit
  import fpcc_pkg::*;
#(
  parameter int EXP_S    = SP_EXP,
  parameter int MAN_S    = SP_MAN,
  parameter int EXP_D    = DP_EXP,
  parameter int MAN_D    = DP_MAN,
  parameter int STAT_W   = 64,
  parameter int CC_BASE  = 10,
  parameter int FTT_LSB  = 14,
  parameter int FTT_W    = 3,
  parameter int FTT_IEEE = 1,
  parameter int NVC_BIT  = 4,
  parameter int NVA_BIT  = 9
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              valid_i,
  input  logic              dbl_i,
  input  logic [1:0]        slot_i,
  input  logic              signaling_i,
  input  logic              trap_en_i,
  input  logic [63:0]       op_a_i,
  input  logic [63:0]       op_b_i,
  output logic [STAT_W-1:0] status_o,
  output logic              trap_o,
  output logic              done_o
);
  localparam int OP_W = 1 + EXP_D + MAN_D;

  logic [OP_W-1:0] raw [2];
  opnd_t           opnd [2];
  rel_e            rel;
  logic            any_nan;

  assign raw[0] = op_a_i[OP_W-1:0];
  assign raw[1] = op_b_i[OP_W-1:0];

  for (genvar i = 0; i < 2; i++) begin : g_unpack
    fpcc_unpack #(
      .EXP_S(EXP_S), .MAN_S(MAN_S), .EXP_D(EXP_D), .MAN_D(MAN_D)
    ) u_unpack (
      .raw_i (raw[i]),
      .dbl_i (dbl_i),
      .opnd_o(opnd[i])
    );
  end

  fpcc_order u_order (
    .a_i      (opnd[0]),
    .b_i      (opnd[1]),
    .rel_o    (rel),
    .any_nan_o(any_nan)
  );

  fpcc_status #(
    .STAT_W(STAT_W), .CC_BASE(CC_BASE), .FTT_LSB(FTT_LSB), .FTT_W(FTT_W),
    .FTT_IEEE(FTT_IEEE), .NVC_BIT(NVC_BIT), .NVA_BIT(NVA_BIT)
  ) u_status (
    .clk        (clk),
    .rst        (rst),
    .valid_i    (valid_i),
    .rel_i      (rel),
    .any_nan_i  (any_nan),
    .slot_i     (slot_i),
    .signaling_i(signaling_i),
    .trap_en_i  (trap_en_i),
    .status_o   (status_o),
    .trap_o     (trap_o),
    .done_o     (done_o)
  );
endmodule

// File: rtl/fpcc_unit_chk.sv
module fpcc_unit_chk #(
  parameter int STAT_W   = 64,
  parameter int CC_BASE  = 10,
  parameter int FTT_LSB  = 14,
  parameter int FTT_W    = 3,
  parameter int FTT_IEEE = 1,
  parameter int NVC_BIT  = 4,
  parameter int NVA_BIT  = 9
) (
  input logic              clk,
  input logic              rst,
  input logic              valid_i,
  input logic [STAT_W-1:0] status_o,
  input logic              trap_o,
  input logic              done_o
);
  logic [7:0] slots;
  assign slots = {status_o[CC_BASE+26 +: 2], status_o[CC_BASE+24 +: 2],
                  status_o[CC_BASE+22 +: 2], status_o[CC_BASE +: 2]};

  p_done_after_valid_r2: assert property (@(posedge clk) disable iff (rst)
    valid_i |=> done_o);

  p_idle_quiet_r2: assert property (@(posedge clk) disable iff (rst)
    !valid_i |=> (!done_o && !trap_o && $stable(status_o)));

  p_trap_marks_r8: assert property (@(posedge clk) disable iff (rst)
    trap_o |-> (done_o && status_o[NVC_BIT] &&
                status_o[FTT_LSB +: FTT_W] == FTT_W'(FTT_IEEE)));

  p_trap_keeps_slots_r8: assert property (@(posedge clk) disable iff (rst)
    trap_o |-> (slots == $past(slots)));

  p_ftt_cleared_r9: assert property (@(posedge clk) disable iff (rst)
    (done_o && !trap_o) |-> (status_o[FTT_LSB +: FTT_W] == '0));

  p_accrued_sticky_r7: assert property (@(posedge clk) disable iff (rst)
    status_o[NVA_BIT] |=> status_o[NVA_BIT]);
endmodule

bind fpcc_unit fpcc_unit_chk #(
  .STAT_W(STAT_W), .CC_BASE(CC_BASE), .FTT_LSB(FTT_LSB), .FTT_W(FTT_W),
  .FTT_IEEE(FTT_IEEE), .NVC_BIT(NVC_BIT), .NVA_BIT(NVA_BIT)
) u_chk (
  .clk(clk), .rst(rst), .valid_i(valid_i),
  .status_o(status_o), .trap_o(trap_o), .done_o(done_o)
);

// File: tb/fpcc_unit_bench.sv
module fpcc_unit_bench;
  localparam int NV = 16;

  logic        clk = 1'b0;
  logic        rst;
  logic        valid_i, dbl_i, signaling_i, trap_en_i;
  logic [1:0]  slot_i;
  logic [63:0] op_a_i, op_b_i;
  logic [63:0] status_o;
  logic        trap_o, done_o;

  int checks = 0;
  int fails  = 0;
  bit finished = 1'b0;
  logic [63:0] model;

  always #2.5 clk = ~clk;

  fpcc_unit u_fpcc_unit (
    .clk(clk), .rst(rst), .valid_i(valid_i), .dbl_i(dbl_i), .slot_i(slot_i),
    .signaling_i(signaling_i), .trap_en_i(trap_en_i), .op_a_i(op_a_i),
    .op_b_i(op_b_i), .status_o(status_o), .trap_o(trap_o), .done_o(done_o)
  );

  // {dbl, slot, signaling, trap_en, a, b, expected relation}
  localparam logic [134:0] VEC [NV] = '{
    {1'b0, 2'd0, 1'b0, 1'b0, 64'h3F800000, 64'h40000000, 2'b01},                 // R3 R6 1<2
    {1'b0, 2'd1, 1'b0, 1'b0, 64'h40000000, 64'h3F800000, 2'b10},                 // R3 R4 2>1
    {1'b0, 2'd2, 1'b0, 1'b0, 64'h00000000, 64'h80000000, 2'b00},                 // R3 +0==-0
    {1'b0, 2'd3, 1'b0, 1'b0, 64'hBF800000, 64'hC0000000, 2'b10},                 // R6 -1>-2
    {1'b0, 2'd0, 1'b0, 1'b0, 64'h7F800000, 64'h3F800000, 2'b10},                 // R6 +inf
    {1'b0, 2'd1, 1'b0, 1'b0, 64'hFF800000, 64'h3F800000, 2'b01},                 // R6 -inf
    {1'b0, 2'd2, 1'b0, 1'b0, 64'h7FC00000, 64'h3F800000, 2'b11},                 // R7 qNaN
    {1'b1, 2'd3, 1'b0, 1'b0, 64'h3FF0000000000000, 64'h4000000000000000, 2'b01}, // R5 double
    {1'b1, 2'd0, 1'b0, 1'b0, 64'hBFE0000000000000, 64'hBFE0000000000000, 2'b00}, // R5 equal
    {1'b0, 2'd1, 1'b0, 1'b0, 64'hFFFFFFFF3F800000, 64'h000000003F800000, 2'b00}, // R5 upper ignored
    {1'b1, 2'd2, 1'b0, 1'b1, 64'h3FF0000000000000, 64'h7FF0000000000001, 2'b11}, // R8 trap
    {1'b0, 2'd3, 1'b1, 1'b1, 64'h7FC00000, 64'h00000000, 2'b11},                 // R10 trap
    {1'b0, 2'd0, 1'b1, 1'b0, 64'h7FC00000, 64'h00000000, 2'b11},                 // R10 R9 no trap
    {1'b1, 2'd3, 1'b0, 1'b0, 64'h7FF0000000000000, 64'h7FEFFFFFFFFFFFFF, 2'b10}, // R11 inf
    {1'b0, 2'd1, 1'b0, 1'b0, 64'h7F800001, 64'h00000000, 2'b11},                 // R11 sNaN
    {1'b1, 2'd2, 1'b0, 1'b0, 64'h8000000000000000, 64'h0000000000000001, 2'b01}  // R3 -0<tiny
  };

  task automatic check(input bit ok, input string req, input logic [63:0] act,
                       input logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1'b1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog actual=%h expected=%h", 64'd0, 64'd1);
    finish_run();
  end

  initial begin
    rst = 1'b1; valid_i = 1'b0; dbl_i = 1'b0; slot_i = 2'd0;
    signaling_i = 1'b0; trap_en_i = 1'b0; op_a_i = '0; op_b_i = '0;
    model = '0;
    repeat (3) @(negedge clk);
    check(status_o == 64'd0, "R1 status in reset", status_o, 64'd0);
    check({done_o, trap_o} == 2'b00, "R1 flags in reset", {62'd0, done_o, trap_o}, 64'd0);
    rst = 1'b0;
    @(negedge clk);
    check(status_o == 64'd0 && !done_o, "R1 after release", status_o, 64'd0);

    for (int i = 0; i < NV; i++) begin
      logic [1:0] rel;
      logic       exp_trap;
      int         pos;
      {dbl_i, slot_i, signaling_i, trap_en_i, op_a_i, op_b_i, rel} = VEC[i];
      exp_trap = (rel == 2'b11) && trap_en_i;
      pos = 10 + ((slot_i == 2'd0) ? 0 : (slot_i == 2'd1) ? 22 : (slot_i == 2'd2) ? 24 : 26);
      model[16:14] = 3'b000;
      if (exp_trap) begin
        model[4] = 1'b1;
        model[16:14] = 3'b001;
      end else begin
        model[pos +: 2] = rel;
        if (rel == 2'b11) model[9] = 1'b1;
      end
      valid_i = 1'b1;
      @(negedge clk);
      valid_i = 1'b0;
      check(done_o == 1'b1, "R2 done pulse", {63'd0, done_o}, 64'd1);
      check(trap_o == exp_trap, exp_trap ? "R8 trap raised" : "R7 no trap",
            {63'd0, trap_o}, {63'd0, exp_trap});
      check(status_o == model, "R3/R4 status word", status_o, model);
      @(negedge clk);
      check(!done_o && !trap_o, "R2 single-cycle pulse", {62'd0, done_o, trap_o}, 64'd0);
      check(status_o == model, "R2 idle hold", status_o, model);
    end

    // R9: ftt cleared by an ordered compare following a trap
    {dbl_i, slot_i, signaling_i, trap_en_i} = {1'b0, 2'd2, 1'b0, 1'b1};
    op_a_i = 64'h7FC00000; op_b_i = 64'h0;
    valid_i = 1'b1; @(negedge clk);
    op_a_i = 64'h3F800000; op_b_i = 64'h3F800000;
    @(negedge clk); valid_i = 1'b0;
    check(status_o[16:14] == 3'b000, "R9 trap type cleared",
          {61'd0, status_o[16:14]}, 64'd0);
    check(status_o[45:10] == {26'd0, 10'd0} ? 1'b0 : status_o[35:34] == 2'b00,
          "R9 slot written", {62'd0, status_o[35:34]}, 64'd0);

    // R1: reset mid-run clears everything
    rst = 1'b1; @(negedge clk); rst = 1'b0;
    check(status_o == 64'd0, "R1 mid-run reset", status_o, 64'd0);
    finish_run();
  end
endmodule